// File: doc/BRIEF.md
# SPI FIFO Interrupt Controller

This block sits between the register file and the shift engine of an SPI port. It holds two small byte queues. The transmit queue is filled by register writes and drained by the engine. The receive queue is filled by the engine and drained by register reads. It also decides when the port raises its transmit and receive interrupt requests.

A two-bit mode field sets a threshold of one to four bytes, which applies to both interrupts:

- The transmit request rises once that many bytes have left the serializer since the last acknowledge.
- The receive request rises while at least that many bytes wait in the receive queue.

Other control inputs work as follows:

- A direction bit picks which of the two requests is active.
- Two flush levels empty the queues and hold them empty.
- A policy bit decides what happens when a byte arrives at a full receive queue: it is lost, or it evicts the oldest byte.

A sticky flag records every receive overflow until software acknowledges it.

Serial shifting, clock generation and chip-select timing belong to the engine and are not part of this block.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it, both levels, `ovf_flag`, `tx_irq` and `rx_irq` read 0.
- R2: The transmit queue holds up to 4 bytes in first-in first-out order. `eng_tx_data` is the oldest byte and `eng_tx_valid` is high when the level is non-zero. A write to a full queue is ignored unless a pop happens in the same cycle. A pop of an empty queue is ignored. An accepted write and pop in the same cycle leave `tx_level` unchanged.
- R3: The receive queue holds up to 4 bytes in first-in first-out order. `rx_rd_data` is the oldest byte. A read of an empty queue is ignored.
- R4: While `tx_flush` is high, the transmit queue is emptied at each clock edge, and every write and pop is ignored.
- R5: While `rx_flush` is high, the receive queue is emptied at each clock edge, incoming bytes and reads are ignored, no overflow is recorded, and both interrupt requests are low from the next cycle.
- R6: With `rx_overwrite` = 0, a byte pushed into a full receive queue with no read in that cycle is discarded, and the stored bytes are kept.
- R7: With `rx_overwrite` = 1, a byte pushed into a full receive queue with no read in that cycle removes the oldest stored byte and is appended, so the level stays at 4.
- R8: `ovf_flag` is set by any push into a full receive queue that has no read in the same cycle, under either policy. It stays set until `ovf_clr`. If a set and a clear occur in the same cycle, the set wins.
- R9: The threshold N equals `irq_mode` + 1. `rx_irq` is registered: it is high one cycle after a cycle in which `xfer_mode` = 0, `rx_flush` = 0 and `rx_level` >= N. With `irq_mode` = 3, this means the queue is full.
- R10: A sent-byte counter counts `eng_byte_done` pulses and saturates at 7. `tx_ack` restarts it from zero; a byte reported in the same cycle as the ack then counts as 1. `tx_irq` is high one cycle after a cycle in which `xfer_mode` = 1, both flush bits are 0 and the counter is at least N.
- R11: `xfer_mode` = 1 selects the transmit request only and 0 selects the receive request only, so the two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_mode | input | 2 | Threshold select, N = value + 1 |
| tx_flush | input | 1 | Hold the transmit queue empty |
| rx_flush | input | 1 | Hold the receive queue empty, drop input, mute interrupts |
| rx_overwrite | input | 1 | Full-queue policy: 1 evicts the oldest byte, 0 drops the new one |
| xfer_mode | input | 1 | 1 selects the transmit interrupt, 0 selects the receive interrupt |
| tx_wr_en | input | 1 | Register write into the transmit queue |
| tx_wr_data | input | 8 | Byte to queue for sending |
| rx_rd_en | input | 1 | Register read from the receive queue |
| rx_rd_data | output | 8 | Oldest received byte |
| tx_ack | input | 1 | Transmit interrupt acknowledge, restarts the sent count |
| ovf_clr | input | 1 | Clears the overflow flag |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_byte_done | input | 1 | Engine finished sending one byte |
| tx_level | output | 3 | Transmit queue occupancy |
| rx_level | output | 3 | Receive queue occupancy |
| ovf_flag | output | 1 | Sticky receive overflow |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that every control input is sampled only at clock edges, so that a flush level or mode change lasts at least one whole cycle. The stimulus drives all inputs on the falling edge and holds them through the next rising edge. It keeps the mode, direction and policy fixed within each phase, and raises the flush bits only briefly. In this way each property sees steady inputs across the window it checks, and the queues still reach both full and empty often.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // Threshold N = mode + 1, never above the queue depth.
  function automatic int unsigned mode_threshold(input logic [1:0] mode,
                                                 input int unsigned depth);
    int unsigned n;
    n = int'(mode) + 1;
    return (n > depth) ? depth : n;
  endfunction

endpackage

// File: rtl/sfi_byte_fifo.sv
module sfi_byte_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          overwrite_en,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, nonempty, do_pop, do_push, adv_rd;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full     = (count == FULL_CNT);
    nonempty = (count != '0);
    do_pop   = pop && nonempty && !flush;
    do_push  = push && !flush && (!full || do_pop || overwrite_en);
    // A push into a full queue with no pop evicts the oldest entry.
    adv_rd   = do_pop || (do_push && full);
  end

  // Storage without reset so it can map onto RAM.
  always_ff @(posedge clk) begin
    if (do_push && !rst) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (adv_rd)  rd_ptr <= ptr_inc(rd_ptr);
      count <= count + CW'(do_push) - CW'(adv_rd);
    end
  end

  assign head = mem[rd_ptr];

  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  a_r4_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));

  a_r2_push_pop_hold: assert property (@(posedge clk) disable iff (rst)
    (do_push && do_pop) |=> $stable(count));

endmodule

// File: rtl/sfi_irq_gen.sv
module sfi_irq_gen
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SENT_W = 3,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    irq_mode,
  input  logic          xfer_mode,
  input  logic          tx_flush,
  input  logic          rx_flush,
  input  logic          byte_done,
  input  logic          tx_ack,
  input  logic [CW-1:0] rx_count,
  output logic          tx_irq,
  output logic          rx_irq
);

  localparam logic [SENT_W-1:0] SENT_MAX = '1;

  logic [SENT_W-1:0] sent;
  int unsigned       thr;
  logic              tx_hit, rx_hit;

  always_comb begin
    thr    = mode_threshold(irq_mode, DEPTH);
    tx_hit = xfer_mode && !tx_flush && !rx_flush && (int'(sent) >= thr);
    rx_hit = !xfer_mode && !rx_flush && (int'(rx_count) >= thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sent <= '0;
    end else if (tx_ack) begin
      sent <= SENT_W'(byte_done);
    end else if (byte_done && sent != SENT_MAX) begin
      sent <= sent + SENT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      tx_irq <= tx_hit;
      rx_irq <= rx_hit;
    end
  end

  a_r11_one_request: assert property (@(posedge clk) disable iff (rst)
    !(tx_irq && rx_irq));

  a_r5_flush_mutes: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> (!tx_irq && !rx_irq));

  a_r10_ack_restart: assert property (@(posedge clk) disable iff (rst)
    (tx_ack && !byte_done) |=> ##1 !tx_irq);

endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned SENT_W = 3,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    irq_mode,
  input  logic          tx_flush,
  input  logic          rx_flush,
  input  logic          rx_overwrite,
  input  logic          xfer_mode,
  input  logic          tx_wr_en,
  input  logic [7:0]    tx_wr_data,
  input  logic          rx_rd_en,
  output logic [7:0]    rx_rd_data,
  input  logic          tx_ack,
  input  logic          ovf_clr,
  input  logic          eng_tx_pop,
  output logic [7:0]    eng_tx_data,
  output logic          eng_tx_valid,
  input  logic          eng_rx_push,
  input  logic [7:0]    eng_rx_data,
  input  logic          eng_byte_done,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level,
  output logic          ovf_flag,
  output logic          tx_irq,
  output logic          rx_irq
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic rx_full, rx_ovf;

  sfi_byte_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk         (clk),
    .rst         (rst),
    .flush       (tx_flush),
    .push        (tx_wr_en),
    .push_data   (tx_wr_data),
    .pop         (eng_tx_pop),
    .overwrite_en(1'b0),
    .head        (eng_tx_data),
    .count       (tx_level)
  );

  sfi_byte_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk         (clk),
    .rst         (rst),
    .flush       (rx_flush),
    .push        (eng_rx_push),
    .push_data   (eng_rx_data),
    .pop         (rx_rd_en),
    .overwrite_en(rx_overwrite),
    .head        (rx_rd_data),
    .count       (rx_level)
  );

  assign eng_tx_valid = (tx_level != '0);

  always_comb begin
    rx_full = (rx_level == FULL_CNT);
    rx_ovf  = eng_rx_push && !rx_flush && rx_full && !rx_rd_en;
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_flag <= 1'b0;
    else if (rx_ovf)  ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  sfi_irq_gen #(.DEPTH(DEPTH), .SENT_W(SENT_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .irq_mode (irq_mode),
    .xfer_mode(xfer_mode),
    .tx_flush (tx_flush),
    .rx_flush (rx_flush),
    .byte_done(eng_byte_done),
    .tx_ack   (tx_ack),
    .rx_count (rx_level),
    .tx_irq   (tx_irq),
    .rx_irq   (rx_irq)
  );

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r6_keep_full: assert property (@(posedge clk) disable iff (rst)
    (rx_full && eng_rx_push && !rx_overwrite && !rx_rd_en && !rx_flush)
      |=> (rx_level == FULL_CNT) && $stable(rx_rd_data));

  a_r4_tx_flush_empty: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> !eng_tx_valid);

endmodule

// File: tb/test_spi_fifo_irq_ctrl.sv
module test_spi_fifo_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] irq_mode;
  logic       tx_flush, rx_flush, rx_overwrite, xfer_mode;
  logic       tx_wr_en, rx_rd_en, tx_ack, ovf_clr;
  logic [7:0] tx_wr_data, rx_rd_data, eng_tx_data, eng_rx_data;
  logic       eng_tx_pop, eng_tx_valid, eng_rx_push, eng_byte_done;
  logic [2:0] tx_level, rx_level;
  logic       ovf_flag, tx_irq, rx_irq;

  always #10 clk = ~clk;

  spi_fifo_irq_ctrl i_spi_fifo_irq_ctrl (
    .clk(clk), .rst(rst), .irq_mode(irq_mode), .tx_flush(tx_flush),
    .rx_flush(rx_flush), .rx_overwrite(rx_overwrite), .xfer_mode(xfer_mode),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .rx_rd_en(rx_rd_en),
    .rx_rd_data(rx_rd_data), .tx_ack(tx_ack), .ovf_clr(ovf_clr),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_tx_valid(eng_tx_valid), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .eng_byte_done(eng_byte_done),
    .tx_level(tx_level), .rx_level(rx_level), .ovf_flag(ovf_flag),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int  sent;
  bit  m_ovf, m_tx_irq, m_rx_irq;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 tx_level", tx_level, txq.size());
    check("R2 eng_tx_valid", eng_tx_valid, txq.size() != 0);
    if (txq.size() != 0) check("R2 eng_tx_data", eng_tx_data, txq[0]);
    check("R3 rx_level", rx_level, rxq.size());
    if (rxq.size() != 0) check("R3 rx_rd_data", rx_rd_data, rxq[0]);
    check("R8 ovf_flag", ovf_flag, m_ovf);
    check("R9 rx_irq", rx_irq, m_rx_irq);
    check("R10 tx_irq", tx_irq, m_tx_irq);
    check("R11 exclusive", tx_irq & rx_irq, 0);
  endtask

  // Advance the model over one rising edge using the inputs now applied.
  task automatic step_model();
    int n;
    bit ovf_set;
    n = int'(irq_mode) + 1;
    // R9 R10 R11 R5: requests from pre-edge state
    m_tx_irq = xfer_mode && !tx_flush && !rx_flush && (sent >= n);
    m_rx_irq = !xfer_mode && !rx_flush && (rxq.size() >= n);
    // R10 sent counter
    if (tx_ack) sent = eng_byte_done ? 1 : 0;
    else if (eng_byte_done && sent < 7) sent++;
    // R4 / R2 transmit queue
    if (tx_flush) txq.delete();
    else begin
      if (eng_tx_pop && txq.size() != 0) void'(txq.pop_front());
      if (tx_wr_en && txq.size() < 4) txq.push_back(tx_wr_data);
    end
    // R5 / R3 / R6 / R7 receive queue
    ovf_set = 0;
    if (rx_flush) rxq.delete();
    else begin
      if (rx_rd_en && rxq.size() != 0) void'(rxq.pop_front());
      if (eng_rx_push) begin
        if (rxq.size() < 4) rxq.push_back(eng_rx_data);
        else begin
          ovf_set = 1;
          if (rx_overwrite) begin
            void'(rxq.pop_front());
            rxq.push_back(eng_rx_data);
          end
        end
      end
    end
    // R8
    if (ovf_set) m_ovf = 1;
    else if (ovf_clr) m_ovf = 0;
  endtask

  function automatic bit pct(input int p);
    return $urandom_range(99) < p;
  endfunction

  task automatic idle_inputs();
    tx_flush = 0; rx_flush = 0; tx_wr_en = 0; rx_rd_en = 0; tx_ack = 0;
    ovf_clr = 0; eng_tx_pop = 0; eng_rx_push = 0; eng_byte_done = 0;
    tx_wr_data = 0; eng_rx_data = 0;
  endtask

  initial begin
    rst = 1; irq_mode = 0; rx_overwrite = 0; xfer_mode = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 tx_level", tx_level, 0);
    check("R1 rx_level", rx_level, 0);
    check("R1 ovf_flag", ovf_flag, 0);
    check("R1 tx_irq", tx_irq, 0);
    check("R1 rx_irq", rx_irq, 0);
    sent = 0; m_ovf = 0; m_tx_irq = 0; m_rx_irq = 0;
    rst = 0;
    @(negedge clk);
    check("R1 after release", {tx_level, rx_level, ovf_flag, tx_irq, rx_irq}, 0);

    for (int ph = 0; ph < 8; ph++) begin
      bool_fill: begin end
      irq_mode     = 2'(ph % 4);
      xfer_mode    = (ph >> 2) & 1;
      rx_overwrite = ((ph >> 1) & 1) ^ ((ph >> 2) & 1);
      for (int c = 0; c < 1500; c++) begin
        bit fill;
        fill          = (ph % 2 == 0);
        tx_flush      = pct(3);
        rx_flush      = pct(3);
        tx_wr_en      = pct(fill ? 60 : 35);
        tx_wr_data    = 8'($urandom);
        eng_tx_pop    = pct(fill ? 30 : 60);
        eng_rx_push   = pct(fill ? 70 : 30);
        eng_rx_data   = 8'($urandom);
        rx_rd_en      = pct(fill ? 20 : 60);
        eng_byte_done = pct(40);
        tx_ack        = pct(12);
        ovf_clr       = pct(10);
        step_model();
        @(negedge clk);
        compare_all();
      end
    end

    // R5 R6 R7: directed full-queue case with R6 policy, then R7 policy
    idle_inputs(); xfer_mode = 0; irq_mode = 2'd3; rx_overwrite = 0;
    rx_flush = 1; step_model(); @(negedge clk); compare_all();
    rx_flush = 0;
    for (int k = 0; k < 6; k++) begin
      eng_rx_push = 1; eng_rx_data = 8'(8'hA0 + k);
      step_model(); @(negedge clk); compare_all();
    end
    check("R6 keeps oldest", rx_rd_data, 8'hA0);
    rx_overwrite = 1;
    for (int k = 0; k < 2; k++) begin
      eng_rx_push = 1; eng_rx_data = 8'(8'hB0 + k);
      step_model(); @(negedge clk); compare_all();
    end
    check("R7 evicted oldest", rx_rd_data, 8'hA2);
    idle_inputs();
    step_model(); @(negedge clk); compare_all();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule